// File: doc/BRIEF.md
# Virtual Page Map with Fault Detection

This block is the translation stage of a memory pipeline. Each cycle it can take one reference: a virtual address, a reference kind and a valid strobe. It splits the address into a virtual page number and a word offset. It looks up the page number in an internal table of page entries. One cycle later it presents the real address, the page entry as it stood before the reference, and a fault verdict that travels with the reference to a later reporting stage.

Each entry holds a real page number, three status flags and one even-parity bit. The flags are: used (set by hardware on a reference), modified (set by hardware on a write) and locked (write-protected, changed only by software). A page carries no separate valid bit. A page is vacant when both modified and locked are set, a combination that has no other meaning.

A reference aborts when it touches a vacant page, writes a locked page, or finds a parity error in the entry. When it aborts, its storage write enable is withheld and the entry is left untouched. Software reads and writes entries through the same request port, using the two map kinds.

Top module: `page_xlate`

## Requirements
- R1: Every accepted request yields exactly one result on the cycle after it (`out_valid`), and no result appears without a request. `out_raddr` is the entry's real page number followed by the request's low `OFS_W` address bits, which are passed through unchanged.
- R2: After reset every entry holds real page 0, used=0, modified=1, locked=1 and parity 0 (a vacant page), and `out_valid`, `out_abort` and `out_wr_en` are 0.
- R3: A fault-free read (kind 00) sets the used flag. A fault-free write (kind 01) sets used and modified. In both cases the parity bit is regenerated so that the XOR of the page number, the three flags and the parity bit is 0.
- R4: A map-write (kind 11) stores the supplied real page number, flags and parity bit exactly as given. It is the only way the locked flag or the page number changes.
- R5: Every result shows on `out_rpn`, `out_flags` ([2]=used, [1]=modified, [0]=locked) and `out_par` the entry as it was before the reference. A map-read (kind 10) leaves the entry unchanged and does not set used.
- R6: A read or write of a vacant page (modified=1 and locked=1) with good parity reports fault code 01.
- R7: A write to a locked, non-vacant page with good parity reports fault code 10. A read of such a page does not fault.
- R8: A read or write whose entry has odd overall parity reports fault code 11. This code takes priority over codes 01 and 10.
- R9: `out_abort` is 1 exactly when the fault code is not 00. A faulting reference leaves its entry unchanged. `out_wr_en` is 1 only for a write (kind 01) with fault code 00.
- R10: Map-read and map-write references never fault, whatever the entry holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | A reference is presented this cycle |
| req_kind | input | 2 | 00 read, 01 write, 10 map-read, 11 map-write |
| req_vaddr | input | VPN_W+OFS_W | Virtual address: page number above, word offset below |
| mw_rpn | input | RPN_W | Real page number stored by a map-write |
| mw_flags | input | 3 | Flags stored by a map-write: [2] used, [1] modified, [0] locked |
| mw_par | input | 1 | Parity bit stored verbatim by a map-write |
| out_valid | output | 1 | Result of the previous cycle's request |
| out_kind | output | 2 | Kind of the reference being reported |
| out_raddr | output | RPN_W+OFS_W | Translated real address |
| out_fault | output | 2 | 00 none, 01 vacant, 10 write to locked page, 11 parity error |
| out_abort | output | 1 | Reference must be dropped downstream |
| out_wr_en | output | 1 | Storage write permitted for this reference |
| out_rpn | output | RPN_W | Entry real page number before the reference |
| out_flags | output | 3 | Entry flags before the reference |
| out_par | output | 1 | Entry parity bit before the reference |

## Verification
All results come from a single output register, so each one is due on the first rising edge after the request edge. The bench drives a request on a falling edge and samples every output on the next falling edge. Entry updates are written on the same edge as the result, so a following reference to the same page sees the new flags at once. The bench therefore issues requests back to back and predicts each result from its own model of the entry table. Flag updates and the fault-leaves-unchanged rule are confirmed through later map-reads of the same page.

// File: rtl/page_xlate_pkg.sv
// Shared types for the page translation stage.
// Assumes the 2-bit kind and fault encodings are fixed by the interface.
package page_xlate_pkg;

    typedef enum logic [1:0] {
        KIND_READ  = 2'b00,
        KIND_WRITE = 2'b01,
        KIND_MAPRD = 2'b10,
        KIND_MAPWR = 2'b11
    } ref_kind_t;

    typedef enum logic [1:0] {
        FLT_NONE   = 2'b00,
        FLT_VACANT = 2'b01,
        FLT_WPROT  = 2'b10,
        FLT_PARITY = 2'b11
    } fault_t;

    // Entry bit positions below the real page number.
    localparam int BIT_USED = 3;
    localparam int BIT_MOD  = 2;
    localparam int BIT_LOCK = 1;
    localparam int BIT_PAR  = 0;
    localparam int META_W   = 4;

endpackage

// File: rtl/map_store.sv
// Page entry table: one register per virtual page, with a combinational
// read port and a single write port.
// Assumes at most one entry is rewritten per cycle; reset loads RST_ENTRY
// into every entry.
module map_store #(
    parameter int VPN_W = 6,
    parameter int ENT_W = 12,
    parameter logic [ENT_W-1:0] RST_ENTRY = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [VPN_W-1:0] rd_idx,
    output logic [ENT_W-1:0] rd_entry,
    input  logic             wr_en,
    input  logic [VPN_W-1:0] wr_idx,
    input  logic [ENT_W-1:0] wr_entry
);
    localparam int DEPTH = 1 << VPN_W;

    logic [ENT_W-1:0] cells [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_cell
        // Hold one entry; load it on reset or when addressed by the write port.
        always_ff @(posedge clk) begin
            if (!rst_n)
                cells[g] <= RST_ENTRY;
            else if (wr_en && (wr_idx == VPN_W'(g)))
                cells[g] <= wr_entry;
        end
    end

    // Present the addressed entry.
    assign rd_entry = cells[rd_idx];

endmodule

// File: rtl/map_classify.sv
// Fault classification for one reference against its entry.
// Assumes entry layout {rpn, used, modified, locked, parity} with even parity
// over the whole entry. Priority: parity error, then vacant, then write
// to a locked page. Map kinds never fault.
module map_classify
    import page_xlate_pkg::*;
#(
    parameter int ENT_W = 12
) (
    input  logic [ENT_W-1:0] entry,
    input  ref_kind_t        kind,
    output fault_t           fault
);
    logic par_bad;
    logic vacant;

    assign par_bad = ^entry;
    assign vacant  = entry[BIT_MOD] & entry[BIT_LOCK];

    // Pick the highest-priority fault for a data reference.
    always_comb begin
        fault = FLT_NONE;
        if (kind == KIND_READ || kind == KIND_WRITE) begin
            if (par_bad)
                fault = FLT_PARITY;
            else if (vacant)
                fault = FLT_VACANT;
            else if (kind == KIND_WRITE && entry[BIT_LOCK])
                fault = FLT_WPROT;
        end
    end

endmodule

// File: rtl/map_update.sv
// Next-value logic for the entry touched by a reference.
// Assumes the fault verdict for the same entry is already known; a faulting
// data reference and a map-read leave the entry as it is.
module map_update
    import page_xlate_pkg::*;
#(
    parameter int ENT_W = 12
) (
    input  logic [ENT_W-1:0] old_entry,
    input  ref_kind_t        kind,
    input  fault_t           fault,
    input  logic [ENT_W-1:0] mw_entry,
    output logic [ENT_W-1:0] new_entry,
    output logic             upd
);
    // Compute the replacement entry and whether it must be written.
    always_comb begin
        new_entry = old_entry;
        upd       = 1'b0;
        unique case (kind)
            KIND_MAPWR: begin
                new_entry = mw_entry;
                upd       = 1'b1;
            end
            KIND_READ, KIND_WRITE: begin
                if (fault == FLT_NONE) begin
                    new_entry[BIT_USED] = 1'b1;
                    if (kind == KIND_WRITE)
                        new_entry[BIT_MOD] = 1'b1;
                    new_entry[BIT_PAR] = ^new_entry[ENT_W-1:1];
                    upd = 1'b1;
                end
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/page_xlate.sv
// Virtual-to-real translation stage with page status flags and map faults.
// One reference per cycle; its result, fault code and the pre-reference
// entry appear one cycle later. Assumes the offset bits need no translation.
module page_xlate
    import page_xlate_pkg::*;
#(
    parameter int VPN_W = 6,
    parameter int OFS_W = 4,
    parameter int RPN_W = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    input  logic [1:0]             req_kind,
    input  logic [VPN_W+OFS_W-1:0] req_vaddr,
    input  logic [RPN_W-1:0]       mw_rpn,
    input  logic [2:0]             mw_flags,
    input  logic                   mw_par,
    output logic                   out_valid,
    output logic [1:0]             out_kind,
    output logic [RPN_W+OFS_W-1:0] out_raddr,
    output logic [1:0]             out_fault,
    output logic                   out_abort,
    output logic                   out_wr_en,
    output logic [RPN_W-1:0]       out_rpn,
    output logic [2:0]             out_flags,
    output logic                   out_par
);
    localparam int ENT_W = RPN_W + META_W;
    // Vacant: modified and locked set; parity of two ones is 0.
    localparam logic [ENT_W-1:0] RST_ENTRY = {{RPN_W{1'b0}}, 4'b0110};

    ref_kind_t          kind;
    logic [VPN_W-1:0]   vpn;
    logic [OFS_W-1:0]   ofs;
    logic [ENT_W-1:0]   cur_entry;
    logic [ENT_W-1:0]   mw_entry;
    logic [ENT_W-1:0]   nxt_entry;
    logic               upd;
    fault_t             fault;

    assign kind     = ref_kind_t'(req_kind);
    assign vpn      = req_vaddr[VPN_W+OFS_W-1:OFS_W];
    assign ofs      = req_vaddr[OFS_W-1:0];
    assign mw_entry = {mw_rpn, mw_flags, mw_par};

    map_store #(
        .VPN_W     (VPN_W),
        .ENT_W     (ENT_W),
        .RST_ENTRY (RST_ENTRY)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (vpn),
        .rd_entry (cur_entry),
        .wr_en    (req_valid & upd),
        .wr_idx   (vpn),
        .wr_entry (nxt_entry)
    );

    map_classify #(.ENT_W(ENT_W)) u_classify (
        .entry (cur_entry),
        .kind  (kind),
        .fault (fault)
    );

    map_update #(.ENT_W(ENT_W)) u_update (
        .old_entry (cur_entry),
        .kind      (kind),
        .fault     (fault),
        .mw_entry  (mw_entry),
        .new_entry (nxt_entry),
        .upd       (upd)
    );

    // Register the result of this cycle's reference for the next stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_kind  <= 2'b00;
            out_raddr <= '0;
            out_fault <= 2'b00;
            out_abort <= 1'b0;
            out_wr_en <= 1'b0;
            out_rpn   <= '0;
            out_flags <= 3'b000;
            out_par   <= 1'b0;
        end else begin
            out_valid <= req_valid;
            out_abort <= req_valid && (fault != FLT_NONE);
            out_wr_en <= req_valid && (kind == KIND_WRITE) && (fault == FLT_NONE);
            if (req_valid) begin
                out_kind  <= req_kind;
                out_raddr <= {cur_entry[ENT_W-1:META_W], ofs};
                out_fault <= fault;
                out_rpn   <= cur_entry[ENT_W-1:META_W];
                out_flags <= cur_entry[BIT_USED:BIT_LOCK];
                out_par   <= cur_entry[BIT_PAR];
            end
        end
    end

endmodule

// File: rtl/page_xlate_checker.sv
// Port-level properties of the translation stage, attached by bind.
module page_xlate_checker #(
    parameter int VPN_W = 6,
    parameter int OFS_W = 4,
    parameter int RPN_W = 8
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   req_valid,
    input logic [VPN_W+OFS_W-1:0] req_vaddr,
    input logic                   out_valid,
    input logic [1:0]             out_kind,
    input logic [RPN_W+OFS_W-1:0] out_raddr,
    input logic [1:0]             out_fault,
    input logic                   out_abort,
    input logic                   out_wr_en,
    input logic [RPN_W-1:0]       out_rpn,
    input logic [2:0]             out_flags,
    input logic                   out_par
);
    logic par_odd;
    assign par_odd = ^{out_rpn, out_flags, out_par};

    AST_RESULT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> out_valid); // R1
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !out_valid); // R1
    AST_OFFSET_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> out_raddr[OFS_W-1:0] == $past(req_vaddr[OFS_W-1:0])); // R1
    AST_PARITY_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_kind[1] && par_odd) |-> out_fault == 2'b11); // R8
    AST_VACANT_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_kind[1] && !par_odd && out_flags[1] && out_flags[0])
        |-> out_fault == 2'b01); // R6
    AST_LOCK_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_kind == 2'b01 && !par_odd && !out_flags[1] && out_flags[0])
        |-> out_fault == 2'b10); // R7
    AST_ABORT_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_abort == (out_fault != 2'b00))); // R9
    AST_WRITE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        out_wr_en |-> (out_valid && out_kind == 2'b01 && !out_abort)); // R9
    AST_MAP_NOFAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_kind[1]) |-> out_fault == 2'b00); // R10

endmodule

bind page_xlate page_xlate_checker #(
    .VPN_W (VPN_W),
    .OFS_W (OFS_W),
    .RPN_W (RPN_W)
) u_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_vaddr (req_vaddr),
    .out_valid (out_valid),
    .out_kind  (out_kind),
    .out_raddr (out_raddr),
    .out_fault (out_fault),
    .out_abort (out_abort),
    .out_wr_en (out_wr_en),
    .out_rpn   (out_rpn),
    .out_flags (out_flags),
    .out_par   (out_par)
);

// File: tb/page_xlate_bench.sv
`timescale 1ns/100ps
module page_xlate_bench;
    localparam int VPN_W = 6;
    localparam int OFS_W = 4;
    localparam int RPN_W = 8;
    localparam int PAGES = 1 << VPN_W;

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic                   req_valid = 1'b0;
    logic [1:0]             req_kind = 2'b00;
    logic [VPN_W+OFS_W-1:0] req_vaddr = '0;
    logic [RPN_W-1:0]       mw_rpn = '0;
    logic [2:0]             mw_flags = 3'b000;
    logic                   mw_par = 1'b0;
    logic                   out_valid;
    logic [1:0]             out_kind;
    logic [RPN_W+OFS_W-1:0] out_raddr;
    logic [1:0]             out_fault;
    logic                   out_abort;
    logic                   out_wr_en;
    logic [RPN_W-1:0]       out_rpn;
    logic [2:0]             out_flags;
    logic                   out_par;

    int checks = 0;
    int errors = 0;

    // Bench model of each entry: {rpn, used, modified, locked, parity}.
    logic [RPN_W+3:0] model [PAGES];

    always #2.5 clk = ~clk;

    page_xlate #(.VPN_W(VPN_W), .OFS_W(OFS_W), .RPN_W(RPN_W)) u_page_xlate (
        .clk (clk), .rst_n (rst_n), .req_valid (req_valid), .req_kind (req_kind),
        .req_vaddr (req_vaddr), .mw_rpn (mw_rpn), .mw_flags (mw_flags), .mw_par (mw_par),
        .out_valid (out_valid), .out_kind (out_kind), .out_raddr (out_raddr),
        .out_fault (out_fault), .out_abort (out_abort), .out_wr_en (out_wr_en),
        .out_rpn (out_rpn), .out_flags (out_flags), .out_par (out_par)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Issue one reference, predict its result from the model, check it one cycle later.
    task automatic issue(input logic [1:0] kind, input int page, input int ofs,
                         input logic [RPN_W-1:0] wrpn, input logic [2:0] wflg, input logic wpar);
        logic [RPN_W+3:0] e;
        logic             bad, vac;
        int               flt;
        string            ftag;
        e   = model[page];
        bad = ^e;
        vac = e[2] & e[1];
        flt = 0;
        if (!kind[1]) begin
            if (bad) flt = 3;
            else if (vac) flt = 1;
            else if (kind == 2'b01 && e[1]) flt = 2;
        end
        ftag = kind[1] ? "R10" : (flt == 3 ? "R8" : (flt == 1 ? "R6" : "R7"));
        @(negedge clk);
        req_valid = 1'b1;
        req_kind  = kind;
        req_vaddr = {VPN_W'(page), OFS_W'(ofs)};
        mw_rpn    = wrpn;
        mw_flags  = wflg;
        mw_par    = wpar;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R1", "out_valid", int'(out_valid), 1);
        chk("R1", "out_raddr", int'(out_raddr), int'({e[RPN_W+3:4], OFS_W'(ofs)}));
        chk("R5", "out_entry", int'({out_rpn, out_flags, out_par}), int'(e));
        chk(ftag, "out_fault", int'(out_fault), flt);
        chk("R9", "out_abort", int'(out_abort), int'(flt != 0));
        chk("R9", "out_wr_en", int'(out_wr_en), int'(kind == 2'b01 && flt == 0));
        // Model update: R3 flag setting, R4 verbatim store, R9 no change on fault.
        if (kind == 2'b11) begin
            model[page] = {wrpn, wflg, wpar};
        end else if (!kind[1] && flt == 0) begin
            e[3] = 1'b1;
            if (kind == 2'b01) e[2] = 1'b1;
            e[0] = ^e[RPN_W+3:1];
            model[page] = e;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [2:0] f;
        logic [RPN_W-1:0] rp;
        logic par;
        for (int p = 0; p < PAGES; p++) model[p] = {{RPN_W{1'b0}}, 4'b0110};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R2: outputs idle after reset.
        chk("R2", "out_valid", int'(out_valid), 0);
        chk("R2", "out_abort", int'(out_abort), 0);
        chk("R2", "out_wr_en", int'(out_wr_en), 0);
        // R2/R5: every entry reads back vacant.
        for (int p = 0; p < PAGES; p++) issue(2'b10, p, p % 16, '0, 3'b000, 1'b0);
        // R6: data references to vacant pages fault and change nothing.
        for (int p = 0; p < PAGES; p++) issue(2'b00, p, (p * 3) % 16, '0, 3'b000, 1'b0);
        for (int p = 0; p < PAGES; p++) issue(2'b01, p, (p * 5) % 16, '0, 3'b000, 1'b0);
        // R4: map-write a mix of clean, locked, vacant and bad-parity entries.
        for (int p = 0; p < PAGES; p++) begin
            rp  = RPN_W'((p * 37 + 11) % 256);
            f   = {1'(p % 8 == 2), 1'(p % 16 == 9 || p % 32 == 14), 1'(p % 4 == 2 || p % 16 == 9)};
            par = ^{rp, f};
            if (p % 8 == 5 || p % 16 == 6 || p % 32 == 14) par = ~par;
            issue(2'b11, p, 0, rp, f, par);
        end
        // R3/R7/R8: back-to-back reads, writes and map-reads on every page.
        for (int p = 0; p < PAGES; p++) begin
            issue(2'b00, p, p % 16, '0, 3'b000, 1'b0);
            issue(2'b01, p, 15 - (p % 16), '0, 3'b000, 1'b0);
            issue(2'b00, p, 7, '0, 3'b000, 1'b0);
            issue(2'b10, p, 1, '0, 3'b000, 1'b0);
        end
        // R4: unlock and repair every page, then write it.
        for (int p = 0; p < PAGES; p++) begin
            rp = RPN_W'(255 - p);
            issue(2'b11, p, 0, rp, 3'b000, ^rp);
            issue(2'b01, p, p % 16, '0, 3'b000, 1'b0);
            issue(2'b10, p, 2, '0, 3'b000, 1'b0);
        end
        // R1: no result without a request.
        @(negedge clk);
        chk("R1", "idle out_valid", int'(out_valid), 0);
        finish_run();
    end

endmodule